// File: doc/BRIEF.md
# Fill-Mode Trace Buffer Writer

This block takes a byte-wide trace stream and stores it, one byte per accepted transfer, into a memory window. Software programs the window with a page-aligned base address and a page-aligned limit address, then sets a starting write position inside the window. The block then drives a byte write port to the address in the write pointer and advances the pointer after each byte. When the byte at the last address below the limit has been written, the pointer returns to the base. The block then stops accepting data and raises a level interrupt. Software then reads out the window, clears the status and re-arms the block.

The same register holds the limit address and the enable bit. Software turns collection off by writing that register back with the enable bit cleared, and the stored limit stays readable. A status word records why collection stopped. The causes are a filled window, an injected translation abort for stage 1 or stage 2, or an attempt to enable with a write pointer outside the window. An ID register reports the write-pointer alignment and the page size as powers of two.

Top module: `trace_fill_engine`

## Requirements
- R1: Each byte accepted on the trace input (valid and ready high at a clock edge) appears on the memory write port one cycle later, with `mem_we` high, `mem_addr` equal to the write pointer at acceptance and `mem_wdata` equal to the byte. The write pointer then advances by one. `mem_we` is low in every other cycle.
- R2: When the accepted byte is at address limit−1, the write pointer becomes the base address. The status word then gets irq (bit 0), wrap (bit 2) and stop (bit 3) set, exception class (bits 9:4) 0 and buffer status (bits 15:10) 1 meaning filled. The `irq` pin is high from the next cycle.
- R3: `trc_ready` is low while the enable bit is clear or the status stop bit is set. No byte is accepted after a wrap until software clears the stop bit.
- R4: Base and limit are stored with the address bits below the page size forced to zero. The write pointer is stored with the bits below 2^ALIGN_LOG2 forced to zero. The ID register (index 4) holds ALIGN_LOG2 in bits 3:0 and log2 of the page size in bits 11:8.
- R5: The limit/control register (index 2) holds enable in bit 0, a fill-mode field in bits 2:1 and a trigger-mode field in bits 4:3, with the limit address above them, and reads back as written. Clearing enable stops collection, and the limit address and write pointer stay unchanged.
- R6: Writes to the status register (index 3) take effect only while enable is clear. Writing irq to 0 drives the `irq` pin low from the next cycle.
- R7: `abort_req` while collecting sets irq and stop, leaves wrap clear and sets exception class 0x24 (stage 1, `abort_stage2`=0) or 0x25 (stage 2, `abort_stage2`=1). Collection stops.
- R8: A write to the write-pointer register (index 1) while enable is set has no effect.
- R9: Writing the limit/control register with enable set, while enable was clear, sets irq and stop with exception class 0x1E when the write pointer is below the base or at or above the new limit. No byte is then accepted.
- R10: `reg_rdata` shows, one cycle after `reg_addr` is presented, register index 0 base, 1 write pointer, 2 limit/control, 3 status, 4 ID, and 0 for any other index.
- R11: Any value of the trigger-mode field is treated as ignore: collection, wrap and stop behave the same for every trigger-mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data |
| trc_valid | input | 1 | Trace byte valid |
| trc_data | input | 8 | Trace byte |
| trc_ready | output | 1 | Engine can take a byte |
| abort_req | input | 1 | Injected translation abort |
| abort_stage2 | input | 1 | Abort is stage 2 when high, stage 1 when low |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | Level interrupt, follows the status irq bit |

## Verification
The bench runs the window up to its last byte with gaps in the valid stream and keeps the stream valid after the wrap. A design that compares against the limit itself instead of limit−1 would write one byte past the window. A design that drops ready late would write an extra byte after the stop. Stage-1 and stage-2 aborts, and an enable with the pointer at exactly the limit, check that each stop cause leaves its own code. Writes to the pointer and to the status while enabled, followed by read-back, catch a block that lets software disturb a running capture. A disable write with the same limit catches a block that loses the limit address when the enable bit is cleared.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  // register indexes
  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_WPTR = 3'd1;
  localparam logic [2:0] RA_LIMC = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_ID   = 3'd4;

  // control bits in the low part of the limit/control register
  localparam int CTL_W   = 5;
  localparam int CTL_EN  = 0;

  // status word layout
  localparam int ST_IRQ     = 0;
  localparam int ST_TRG     = 1;
  localparam int ST_WRAP    = 2;
  localparam int ST_STOP    = 3;
  localparam int ST_EC_LSB  = 4;
  localparam int EC_W       = 6;
  localparam int ST_BSC_LSB = 10;
  localparam int BSC_W      = 6;
  localparam int ST_USED    = 16;

  localparam logic [EC_W-1:0]  EC_OTHER  = 6'h00;
  localparam logic [EC_W-1:0]  EC_RANGE  = 6'h1E;
  localparam logic [EC_W-1:0]  EC_ABT_S1 = 6'h24;
  localparam logic [EC_W-1:0]  EC_ABT_S2 = 6'h25;
  localparam logic [BSC_W-1:0] BSC_FILLED = 6'h01;
endpackage

// File: rtl/tfe_status.sv
module tfe_status
  import tfe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         wrap_evt,
  input  logic         abort_evt,
  input  logic         abort_s2,
  input  logic         range_evt,
  output logic [W-1:0] status_o,
  output logic         irq_o,
  output logic         stop_o
);
  localparam logic [W-1:0] ST_MASK = W'((64'd1 << ST_USED) - 64'd1);

  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sw_we && !en) begin
      st_d = sw_data & ST_MASK;
    end else begin
      if (wrap_evt) begin
        st_d[ST_IRQ]  = 1'b1;
        st_d[ST_WRAP] = 1'b1;
        st_d[ST_STOP] = 1'b1;
        st_d[ST_EC_LSB +: EC_W]   = EC_OTHER;
        st_d[ST_BSC_LSB +: BSC_W] = BSC_FILLED;
      end
      if (abort_evt) begin
        st_d[ST_IRQ]  = 1'b1;
        st_d[ST_STOP] = 1'b1;
        st_d[ST_EC_LSB +: EC_W] = abort_s2 ? EC_ABT_S2 : EC_ABT_S1;
      end
      if (range_evt) begin
        st_d[ST_IRQ]  = 1'b1;
        st_d[ST_STOP] = 1'b1;
        st_d[ST_EC_LSB +: EC_W] = EC_RANGE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign status_o = st_q;
  assign irq_o    = st_q[ST_IRQ];
  assign stop_o   = st_q[ST_STOP];
endmodule

// File: rtl/tfe_wptr.sv
module tfe_wptr #(
  parameter int W          = 32,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  input  logic         tvalid,
  input  logic [7:0]   tdata,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] wptr_o,
  output logic         wrap_evt,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [7:0]   mem_wdata
);
  localparam logic [W-1:0] ALIGN_MASK = {W{1'b1}} << ALIGN_LOG2;

  logic [W-1:0] wptr_q;
  logic         fire, at_end;

  assign fire     = tvalid && active;
  assign at_end   = (wptr_q == (limit - W'(1)));
  assign wrap_evt = fire && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= fire;
      if (fire) begin
        mem_addr  <= wptr_q;
        mem_wdata <= tdata;
        wptr_q    <= at_end ? base : wptr_q + W'(1);
      end else if (sw_we) begin
        wptr_q <= sw_data & ALIGN_MASK;
      end
    end
  end

  assign wptr_o = wptr_q;
endmodule

// File: rtl/trace_fill_engine.sv
module trace_fill_engine
  import tfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              trc_valid,
  input  logic [7:0]        trc_data,
  output logic              trc_ready,
  input  logic              abort_req,
  input  logic              abort_stage2,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq
);
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_LOG2;
  localparam logic [ADDR_W-1:0] ID_WORD =
    ADDR_W'(ALIGN_LOG2) | (ADDR_W'(PAGE_LOG2) << 8);

  generate
    if (ALIGN_LOG2 > 11 || ALIGN_LOG2 > PAGE_LOG2 || ADDR_W < ST_USED) begin : g_bad_cfg
      $error("trace_fill_engine: unsupported alignment or address width");
    end
  endgenerate

  logic [ADDR_W-1:0] base_q, lim_q, wptr, status;
  logic [CTL_W-1:0]  ctl_q;
  logic              en, stop, active, wrap_evt, range_evt;
  logic              wr_base, wr_wptr, wr_limc, wr_stat;

  assign en      = ctl_q[CTL_EN];
  assign active  = en && !stop;
  assign wr_base = reg_wr && (reg_addr == RA_BASE);
  assign wr_wptr = reg_wr && (reg_addr == RA_WPTR);
  assign wr_limc = reg_wr && (reg_addr == RA_LIMC);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);

  // enabling from the disabled state validates the pointer against the new window
  assign range_evt = wr_limc && reg_wdata[CTL_EN] && !en &&
                     ((wptr < base_q) || (wptr >= (reg_wdata & PAGE_MASK)));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_base) base_q <= reg_wdata & PAGE_MASK;
      if (wr_limc) begin
        lim_q <= reg_wdata & PAGE_MASK;
        ctl_q <= reg_wdata[CTL_W-1:0];
      end
    end
  end

  tfe_wptr #(.W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_wptr (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .base     (base_q),
    .limit    (lim_q),
    .tvalid   (trc_valid),
    .tdata    (trc_data),
    .sw_we    (wr_wptr && !en),
    .sw_data  (reg_wdata),
    .wptr_o   (wptr),
    .wrap_evt (wrap_evt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  tfe_status #(.W(ADDR_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sw_we    (wr_stat),
    .sw_data  (reg_wdata),
    .wrap_evt (wrap_evt),
    .abort_evt(abort_req && active),
    .abort_s2 (abort_stage2),
    .range_evt(range_evt),
    .status_o (status),
    .irq_o    (irq),
    .stop_o   (stop)
  );

  assign trc_ready = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        RA_BASE: reg_rdata <= base_q;
        RA_WPTR: reg_rdata <= wptr;
        RA_LIMC: reg_rdata <= lim_q | ADDR_W'(ctl_q);
        RA_STAT: reg_rdata <= status;
        RA_ID:   reg_rdata <= ID_WORD;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tfe_checker.sv
module tfe_checker
  import tfe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              reg_wdata0,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic [7:0]        trc_data,
  input logic              abort_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              irq,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W-1:0] base,
  input logic [ADDR_W-1:0] lim,
  input logic              en,
  input logic [15:0]       status
);
  logic fire;
  assign fire = trc_valid && trc_ready;

  a_r1_mem_write: assert property (@(posedge clk) disable iff (rst)
    fire |=> (mem_we && mem_addr == $past(wptr) && mem_wdata == $past(trc_data)));

  a_r1_no_stray_write: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !mem_we);

  a_r2_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
    (fire && wptr == lim - ADDR_W'(1)) |=>
      (wptr == $past(base) && irq && status[ST_WRAP] && status[ST_STOP]
       && status[ST_BSC_LSB +: BSC_W] == BSC_FILLED));

  a_r3_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    (!en || status[ST_STOP]) |=> !mem_we);

  a_r6_status_locked: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_STAT && en && !abort_req && !fire) |=> $stable(status));

  a_r7_abort_code: assert property (@(posedge clk) disable iff (rst)
    (abort_req && trc_ready) |=>
      (irq && status[ST_STOP] &&
       (status[ST_EC_LSB +: EC_W] == EC_ABT_S1 || status[ST_EC_LSB +: EC_W] == EC_ABT_S2)));

  a_r8_wptr_locked: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_WPTR && en && !fire) |=> $stable(wptr));

  a_r9_range_below_base: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_LIMC && reg_wdata0 && !en && wptr < base) |=>
      (status[ST_STOP] && status[ST_EC_LSB +: EC_W] == EC_RANGE));
endmodule

bind trace_fill_engine tfe_checker #(.ADDR_W(ADDR_W)) u_tfe_checker (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata0(reg_wdata[0]),
  .trc_valid (trc_valid),
  .trc_ready (trc_ready),
  .trc_data  (trc_data),
  .abort_req (abort_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq       (irq),
  .wptr      (wptr),
  .base      (base_q),
  .lim       (lim_q),
  .en        (en),
  .status    (status[15:0])
);

// File: tb/trace_fill_engine_bench.sv
`timescale 1ns/1ps
module trace_fill_engine_bench;
  localparam int AW = 32;
  localparam logic [31:0] PMASK = 32'hFFFF_FFC0;
  localparam logic [31:0] AMASK = 32'hFFFF_FFF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic trc_valid = 1'b0;
  logic [7:0] trc_data = 8'h00;
  logic trc_ready;
  logic abort_req = 1'b0;
  logic abort_stage2 = 1'b0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_fill_engine #(.ADDR_W(AW), .PAGE_BYTES(64), .ALIGN_LOG2(3)) u_trace_fill_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trc_valid(trc_valid), .trc_data(trc_data), .trc_ready(trc_ready),
    .abort_req(abort_req), .abort_stage2(abort_stage2), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated at each rising edge from the inputs the bench drives
  logic [31:0] m_base = 0, m_lim = 0, m_wptr = 0, exp_addr = 0, exp_rdata = 0;
  logic [4:0]  m_ctl = 0;
  logic        m_irq = 0, m_trg = 0, m_wrap = 0, m_stop = 0, exp_we = 0;
  logic [5:0]  m_ec = 0, m_bsc = 0;
  logic [7:0]  exp_wd = 0;

  function automatic logic [31:0] m_status();
    return {16'h0, m_bsc, m_ec, m_stop, m_wrap, m_trg, m_irq};
  endfunction

  always @(posedge clk) begin : model
    logic act, fire, wrap, rng;
    logic [31:0] lw;
    if (rst) begin
      m_base = 0; m_lim = 0; m_wptr = 0; m_ctl = 0;
      m_irq = 0; m_trg = 0; m_wrap = 0; m_stop = 0; m_ec = 0; m_bsc = 0;
      exp_we = 0; exp_rdata = 0;
    end else begin
      act  = m_ctl[0] && !m_stop;
      fire = trc_valid && act;
      wrap = fire && (m_wptr == m_lim - 1);
      lw   = reg_wdata & PMASK;
      rng  = reg_wr && reg_addr == 3'd2 && reg_wdata[0] && !m_ctl[0] &&
             (m_wptr < m_base || m_wptr >= lw);
      case (reg_addr)
        3'd0: exp_rdata = m_base;
        3'd1: exp_rdata = m_wptr;
        3'd2: exp_rdata = m_lim | {27'h0, m_ctl};
        3'd3: exp_rdata = m_status();
        3'd4: exp_rdata = 32'h0000_0603;
        default: exp_rdata = 0;
      endcase
      exp_we = fire;
      if (fire) begin exp_addr = m_wptr; exp_wd = trc_data; end
      if (reg_wr && reg_addr == 3'd3 && !m_ctl[0]) begin
        m_irq = reg_wdata[0]; m_trg = reg_wdata[1]; m_wrap = reg_wdata[2];
        m_stop = reg_wdata[3]; m_ec = reg_wdata[9:4]; m_bsc = reg_wdata[15:10];
      end else begin
        if (wrap) begin m_irq = 1; m_wrap = 1; m_stop = 1; m_ec = 0; m_bsc = 1; end
        if (abort_req && act) begin m_irq = 1; m_stop = 1; m_ec = abort_stage2 ? 6'h25 : 6'h24; end
        if (rng) begin m_irq = 1; m_stop = 1; m_ec = 6'h1E; end
      end
      if (fire) m_wptr = wrap ? m_base : m_wptr + 1;
      else if (reg_wr && reg_addr == 3'd1 && !m_ctl[0]) m_wptr = reg_wdata & AMASK;
      if (reg_wr && reg_addr == 3'd0) m_base = reg_wdata & PMASK;
      if (reg_wr && reg_addr == 3'd2) begin m_lim = lw; m_ctl = reg_wdata[4:0]; end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 trc_ready vs model", {31'h0, trc_ready}, {31'h0, m_ctl[0] && !m_stop});
      chk("R2/R6 irq pin vs model", {31'h0, irq}, {31'h0, m_irq});
      chk("R1 mem_we vs model", {31'h0, mem_we}, {31'h0, exp_we});
      if (exp_we) begin
        chk("R1 mem_addr vs model", mem_addr, exp_addr);
        chk("R1 mem_wdata vs model", {24'h0, mem_wdata}, {24'h0, exp_wd});
      end
      chk("R10 reg_rdata vs model", reg_rdata, exp_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic stream(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      trc_valid = (i % 3 != 2);
      trc_data  = seed + 8'(i * 7);
    end
    @(posedge clk); #1;
    trc_valid = 1'b0;
  endtask

  task automatic abort_pulse(input logic s2);
    @(posedge clk); #1;
    abort_req = 1'b1; abort_stage2 = s2;
    @(posedge clk); #1;
    abort_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    started = 1'b1;
    @(negedge clk);
    chk("R3 reset ready low", {31'h0, trc_ready}, 32'h0);
    chk("R6 reset irq low", {31'h0, irq}, 32'h0);
    rd(3'd0, 32'h0, "R10 reset base");
    rd(3'd3, 32'h0, "R10 reset status");
    rd(3'd4, 32'h0000_0603, "R4 ID alignment and page fields");
    rd(3'd6, 32'h0, "R10 unused index reads zero");

    // window 0x1000..0x107F, start mid-window
    wr(3'd0, 32'h0000_1013);
    rd(3'd0, 32'h0000_1000, "R4 base page aligned");
    wr(3'd1, 32'h0000_1035);
    rd(3'd1, 32'h0000_1030, "R4 write pointer aligned");
    wr(3'd2, 32'h0000_1081);
    rd(3'd2, 32'h0000_1081, "R5 limit/control readback");
    stream(150, 8'h11);
    rd(3'd3, 32'h0000_040D, "R2 status after wrap");
    rd(3'd1, 32'h0000_1000, "R2 write pointer back at base");
    @(negedge clk);
    chk("R3 ready low after wrap", {31'h0, trc_ready}, 32'h0);

    // writes while enabled are ignored
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0000_040D, "R6 status write ignored while enabled");
    wr(3'd1, 32'h0000_1050);
    rd(3'd1, 32'h0000_1000, "R8 pointer write ignored while enabled");

    // disable keeps limit; clear status drops irq
    wr(3'd2, 32'h0000_1080);
    rd(3'd2, 32'h0000_1080, "R5 limit kept after disable");
    wr(3'd3, 32'h0);
    @(negedge clk);
    chk("R6 irq cleared by status write", {31'h0, irq}, 32'h0);

    // trigger field 3, fill field 0: collection unchanged, then stage-2 abort
    wr(3'd1, 32'h0000_1047);
    rd(3'd1, 32'h0000_1040, "R4 pointer alignment");
    wr(3'd2, 32'h0000_1099);
    rd(3'd2, 32'h0000_1099, "R11 control fields readback");
    stream(20, 8'h40);
    rd(3'd1, 32'h0000_104E, "R11 collection with trigger field 3");
    abort_pulse(1'b1);
    rd(3'd3, 32'h0000_0259, "R7 stage-2 abort status");

    // enable with pointer at the limit
    wr(3'd2, 32'h0000_1040);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0000_1040);
    wr(3'd2, 32'h0000_1041);
    rd(3'd3, 32'h0000_01E9, "R9 range error status");
    stream(6, 8'h90);
    rd(3'd1, 32'h0000_1040, "R9 no collection after range error");

    // disable mid-stream
    wr(3'd2, 32'h0000_1080);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_1081);
    stream(10, 8'hA0);
    wr(3'd2, 32'h0000_1080);
    rd(3'd1, 32'h0000_1007, "R5 pointer held after disable");
    stream(5, 8'hB0);
    rd(3'd1, 32'h0000_1007, "R3 no bytes taken while disabled");

    // stage-1 abort
    wr(3'd2, 32'h0000_1081);
    abort_pulse(1'b0);
    rd(3'd3, 32'h0000_0249, "R7 stage-1 abort status");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule